// File: doc/BRIEF.md
# Local Interrupt Controller Enable Gate

This block sets whether a per-processor local interrupt controller is enabled, and which local requests reach the core. It holds three kinds of state. A base/status register holds a global enable and a read-only bootstrap-processor flag. A spurious-vector register holds a software enable and a vector field. A table of six local vector entries holds a mask bit and a vector field for each entry. The six sources, by index, are: external pin 0 (0), external pin 1 (1), timer (2), performance counter (3), thermal sensor (4) and error detector (5).

A request reaches the core only when the global enable, the software enable and the unmask conditions all allow it. The block applies this gate combinationally, in the same cycle as the request, and keeps no pending state. The parameter `STICKY_DISABLE` selects between two variants. With 1, the global enable cannot be set again once it is cleared, and only a hardware reset restores it. With 0, software can clear and set the global enable freely. Software uses one write/read port with a 3-bit address: 0 is the base register, 1 is the spurious register, and 2+i is the table entry for source i. Reads are combinational on the address.

Top module: `lic_enable_gate`

## Requirements
- R1: On a synchronous reset, the global enable is 1 and the software enable is 0. Both vector fields are 0 and every mask is 1. The bootstrap flag captures the `boot_strap` input.
- R2: In the base register, bit 11 reads as the global enable and bit 8 reads as the bootstrap flag. All other bits read 0, and writes to bit 8 have no effect.
- R3: `feature_present` equals the global enable.
- R4: With `STICKY_DISABLE`=0, writing 0 to bit 11 clears the global enable, and writing 1 to bit 11 sets it again without a reset.
- R5: With `STICKY_DISABLE`=1, once the global enable is 0, writes of 1 to bit 11 are ignored until reset.
- R6: A write that clears the global enable returns the spurious register and all table entries to their reset values in the same clock.
- R7: While the global enable is 0, the spurious register and the table entries read 0 and ignore writes. The exception is R10.
- R8: The software enable is bit 8 of the spurious register. While it is 0 and the global enable is 1, every mask (bit 16 of an entry) reads 1 and writes cannot clear it. Clearing the software enable sets all masks. After the software enable is set again, the masks stay 1 until they are written.
- R9: `fwd_req[i]` is `src_req[i]` when the global enable is 1, the software enable is 1 and mask i is 0. Otherwise it is 0, in the same cycle.
- R10: With `STICKY_DISABLE`=1 and the global enable at 0, the entries for sources 3 and 4 stay readable and writable. Such a source is forwarded whenever its mask is 0.
- R11: The vector fields (bits 7:0 of the spurious register and of each entry) store written values and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| boot_strap | input | 1 | Bootstrap strap, captured during reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| src_req | input | 6 | Local source requests |
| fwd_req | output | 6 | Requests forwarded to the core |
| feature_present | output | 1 | Controller visible as present |

## Verification
The hardest state to reach from the ports is the sticky-disabled variant after the global enable has been cleared. In that state, only the performance and thermal entries are live, and every attempt to set the enable again must fail. The state ends only at a reset. The bench drives two instances, one of each variant, with the same writes. Directed sequences clear the enable, program the two surviving entries and retry the enable. Random writes, biased to keep the enable set most of the time, then walk the mask and software-enable interactions. A final reset recovers the sticky instance.

// File: rtl/lic_enable_gate.sv
module lic_enable_gate #(
  parameter bit STICKY_DISABLE = 1'b0,
  parameter int VEC_W          = 8,
  parameter int DATA_W         = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_strap,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [5:0]        src_req,
  output logic [5:0]        fwd_req,
  output logic              feature_present
);
  localparam int NSRC     = 6;
  localparam int GE_BIT   = 11;
  localparam int BSP_BIT  = 8;
  localparam int SWEN_BIT = 8;
  localparam int MASK_BIT = 16;
  localparam logic [NSRC-1:0] KEEP = STICKY_DISABLE ? 6'b011000 : 6'b000000;

  logic                 gen, bsp, swen;
  logic [VEC_W-1:0]     svec;
  logic [NSRC-1:0]      mask;
  logic [VEC_W-1:0]     vec [NSRC];
  logic [NSRC-1:0]      live;

  assign live            = {NSRC{gen}} | KEEP;
  assign feature_present = gen;
  assign fwd_req = src_req & ~mask & ({NSRC{gen & swen}} | (KEEP & {NSRC{~gen}}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen  <= 1'b1;
      bsp  <= boot_strap;
      swen <= 1'b0;
      svec <= '0;
      mask <= '1;
      for (int i = 0; i < NSRC; i++) vec[i] <= '0;
    end else if (wr_en) begin
      if (addr == 3'd0) begin
        if (gen && !wr_data[GE_BIT]) begin
          gen  <= 1'b0;
          swen <= 1'b0;
          svec <= '0;
          mask <= '1;
          for (int i = 0; i < NSRC; i++) vec[i] <= '0;
        end else if (wr_data[GE_BIT] && !STICKY_DISABLE) begin
          gen <= 1'b1;
        end
      end else if (addr == 3'd1) begin
        if (gen) begin
          swen <= wr_data[SWEN_BIT];
          svec <= wr_data[VEC_W-1:0];
          if (!wr_data[SWEN_BIT]) mask <= '1;
        end
      end else begin
        for (int i = 0; i < NSRC; i++) begin
          if (addr == 3'(i + 2) && live[i]) begin
            vec[i]  <= wr_data[VEC_W-1:0];
            mask[i] <= wr_data[MASK_BIT] | (gen & ~swen);
          end
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == 3'd0) begin
      rd_data[GE_BIT]  = gen;
      rd_data[BSP_BIT] = bsp;
    end else if (addr == 3'd1) begin
      if (gen) begin
        rd_data[SWEN_BIT]  = swen;
        rd_data[VEC_W-1:0] = svec;
      end
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (addr == 3'(i + 2) && live[i]) begin
          rd_data[MASK_BIT]  = mask[i];
          rd_data[VEC_W-1:0] = vec[i];
        end
      end
    end
  end

  a_r8_masks_while_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && !swen) |-> (&mask));
  a_r9_no_fwd_when_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && (|fwd_req)) |-> swen);
  a_r9_fwd_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_req & ~src_req) == '0);
  a_r6_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen) |-> (!swen && (&mask) && svec == '0));

  generate
    if (STICKY_DISABLE) begin : g_sticky
      a_r5_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |=> !gen);
    end else begin : g_free
      a_r10_none_live_off: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> (fwd_req == '0));
    end
  endgenerate
endmodule

// File: tb/test_lic_enable_gate.sv
module test_lic_enable_gate;
  logic clk = 0, rst_n = 0, boot_strap = 1, wr_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wr_data = 0;
  logic [5:0] src_req = 0;
  logic [31:0] rd [2];
  logic [5:0] fw [2];
  logic fp [2];
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  lic_enable_gate #(.STICKY_DISABLE(1'b0)) i_lic_enable_gate (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd[0]), .src_req(src_req), .fwd_req(fw[0]),
    .feature_present(fp[0]));
  lic_enable_gate #(.STICKY_DISABLE(1'b1)) i_lic_enable_gate_sticky (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd[1]), .src_req(src_req), .fwd_req(fw[1]),
    .feature_present(fp[1]));

  logic m_gen [2], m_swen [2], m_bsp;
  logic [7:0] m_svec [2];
  logic [5:0] m_mask [2];
  logic [7:0] m_vec [2][6];

  function automatic bit keep(int v, int i);
    return v == 1 && (i == 3 || i == 4);
  endfunction

  task automatic model_reset(logic strap);
    m_bsp = strap;
    for (int v = 0; v < 2; v++) begin
      m_gen[v] = 1; m_swen[v] = 0; m_svec[v] = 0; m_mask[v] = '1;
      for (int i = 0; i < 6; i++) m_vec[v][i] = 0;
    end
  endtask

  task automatic model_write(int v, int a, logic [31:0] d);
    if (a == 0) begin
      if (m_gen[v] && !d[11]) begin
        m_gen[v] = 0; m_swen[v] = 0; m_svec[v] = 0; m_mask[v] = '1;
        for (int i = 0; i < 6; i++) m_vec[v][i] = 0;
      end else if (d[11] && v == 0) m_gen[v] = 1;
    end else if (a == 1) begin
      if (m_gen[v]) begin
        if (!d[8]) m_mask[v] = '1;
        m_swen[v] = d[8]; m_svec[v] = d[7:0];
      end
    end else begin
      int i = a - 2;
      if (m_gen[v]) begin
        m_vec[v][i] = d[7:0]; m_mask[v][i] = d[16] | !m_swen[v];
      end else if (keep(v, i)) begin
        m_vec[v][i] = d[7:0]; m_mask[v][i] = d[16];
      end
    end
  endtask

  function automatic logic [31:0] model_rd(int v, int a);
    logic [31:0] r = 0;
    if (a == 0) begin r[11] = m_gen[v]; r[8] = m_bsp; end
    else if (a == 1) begin
      if (m_gen[v]) begin r[8] = m_swen[v]; r[7:0] = m_svec[v]; end
    end else if (m_gen[v] || keep(v, a - 2)) begin
      r[16] = m_mask[v][a-2]; r[7:0] = m_vec[v][a-2];
    end
    return r;
  endfunction

  function automatic logic [5:0] model_fw(int v, logic [5:0] req);
    logic [5:0] f = 0;
    for (int i = 0; i < 6; i++)
      f[i] = req[i] && !m_mask[v][i] && ((m_gen[v] && m_swen[v]) || (!m_gen[v] && keep(v, i)));
    return f;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = 3'(a); wr_data = d; wr_en = 1; src_req = 0;
    @(posedge clk); #1;
    wr_en = 0;
    for (int v = 0; v < 2; v++) model_write(v, a, d);
  endtask

  task automatic sweep(string tag);
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      for (int v = 0; v < 2; v++) chk({tag, " R2 R7 R8 read"}, rd[v], model_rd(v, a));
    end
    for (int k = 0; k < 4; k++) begin
      src_req = (k == 0) ? 6'h3f : 6'($urandom); #1;
      for (int v = 0; v < 2; v++) begin
        chk({tag, " R9 fwd"}, 32'(fw[v]), 32'(model_fw(v, src_req)));
        chk({tag, " R3 present"}, 32'(fp[v]), 32'(m_gen[v]));
      end
    end
    src_req = 0;
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk); rst_n = 0; boot_strap = strap;
    repeat (3) @(posedge clk);
    #1; model_reset(strap);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1);
    sweep("R1");
    wr(2, 32'h0000_0011);                 sweep("R8 write while sw off");
    wr(1, 32'h0000_01A5);                 sweep("R11 spurious vector");
    sweep("R8 masks stay set after enable");
    for (int i = 0; i < 6; i++) wr(2 + i, 32'h40 + i);
    sweep("R9 R11 all unmasked");
    wr(5, 32'h0001_0077);                 sweep("R9 one masked");
    wr(1, 32'h0000_0033);                 sweep("R8 sw disable sets masks");
    wr(1, 32'h0000_0133);                 sweep("R8 re-enable keeps masks");
    wr(0, 32'h0000_0100);                 sweep("R6 R2 global clear");
    wr(1, 32'h0000_01FF);                 sweep("R7 spurious ignored");
    wr(2, 32'h0000_0012);                 sweep("R7 entry ignored");
    wr(5, 32'h0000_0055); wr(6, 32'h0000_0066); sweep("R10 kept sources");
    wr(0, 32'h0000_0800);                 sweep("R4 R5 set retry");
    wr(1, 32'h0000_0101); wr(4, 32'h0000_0009); sweep("R4 R5 after retry");
    for (int n = 0; n < 300; n++) begin
      logic [31:0] d = $urandom;
      d[11] = ($urandom % 12) != 0;
      wr(int'($urandom % 8), d);
      if (n % 5 == 0) sweep("random R9");
    end
    do_reset(1'b0);
    sweep("R1 R5 reset recovers");
    wr(0, 32'h0000_0900);                 sweep("R2 flag read only");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule